// File: doc/BRIEF.md
# Byte Command Serial Port Decoder

This block is the receive and transmit front end of a four-wire synchronous serial slave. A host selects the port by pulling an active-low select line low, clocks command and data bits in on a serial data input, and collects read results from a serial data output. Every eight bits received form one command byte, and that byte is sorted into one of four kinds: a synchronising filler byte, an instruction, a register write or a register read. Instructions leave the block as a one-cycle strobe with the command code attached. Write commands collect the three bytes that follow into a 24-bit word and issue a single write strobe. Read commands fetch a register value over a combinational read port and shift it out, most significant bit first.

All serial inputs are brought into the core clock domain through synchronisers. Rising edges of the serial clock sample input data, and falling edges advance the output data. Decoding of input bytes continues while a readout is shifting. A further read command restarts the readout with the new value. Instructions, writes and filler bytes leave a readout untouched.

Top module: `cmd_port`

## Requirements
- R1: While the select line is high, the partial byte count is cleared, a pending write and any readout are dropped, sdo is held low, and no strobe is issued. A byte left incomplete when the select line rises has no effect on the next selection.
- R2: Data is sampled on rising serial clock edges, most significant bit first. A command is decoded as soon as its eighth bit arrives.
- R3: The bytes 0xFF and 0xFE are synchronising fillers. They issue no strobe and do not disturb a readout.
- R4: A byte with bits [7:6] = 11 that is not a filler issues one instr_stb pulse, with instr_code equal to the whole byte.
- R5: A byte with bits [7:6] = 01 is a write to the address in bits [5:1]. The next three bytes, first byte most significant, are taken as data and never decoded as commands. After the third byte, reg_wr_stb pulses with that address and the 24-bit value.
- R6: A byte with bits [7:6] = 00 pulses reg_rd_stb with the address in bits [5:1] and captures reg_rd_data. The value goes out on sdo MSB first, one bit per falling serial clock edge, starting at the falling edge that follows the command's last bit. After 24 bits, sdo stays low.
- R7: A read command that arrives during a readout ends it. The new value starts at the next falling edge.
- R8: Instruction, write command and write data bytes received during a readout do not alter the bits shifted out.
- R9: A byte with bits [7:6] = 10 is ignored.
- R10: Every strobe is a single core-clock pulse, and at most one strobe is issued per received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select from host |
| sclk | input | 1 | Serial bit clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| instr_stb | output | 1 | Instruction received pulse |
| instr_code | output | 8 | Instruction byte, valid with instr_stb |
| reg_wr_stb | output | 1 | Register write pulse |
| reg_wr_addr | output | 5 | Register write address |
| reg_wr_data | output | 24 | Register write value |
| reg_rd_stb | output | 1 | Register read request pulse |
| reg_rd_addr | output | 5 | Register read address |
| reg_rd_data | input | 24 | Register value for reg_rd_addr, sampled with reg_rd_stb |

## Verification
The decoder is driven with byte streams that place each command kind alone and then in combinations. An asymmetric instruction code exposes bit-order mistakes. Write data bytes that look like fillers or instructions show whether they are wrongly decoded as commands. Readouts padded with filler bytes, and readouts mixed with instructions and writes, separate "decoding continues" from "readout disturbed". A second read in the middle of a readout checks the restart. A select line raised mid-byte, mid-write or mid-readout checks that stale state is dropped.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = 5;

    localparam logic [CMD_W-1:0] FILL_HI = 8'hFF;
    localparam logic [CMD_W-1:0] FILL_LO = 8'hFE;

    typedef enum logic [2:0] {
        K_NONE,
        K_FILL,
        K_INSTR,
        K_WRITE,
        K_READ
    } cmd_kind_e;

    // Sort a complete command byte into its kind.
    function automatic cmd_kind_e classify(input logic [CMD_W-1:0] b);
        cmd_kind_e k;
        if (b == FILL_HI || b == FILL_LO) begin
            k = K_FILL;
        end else begin
            case (b[7:6])
                2'b11:   k = K_INSTR;
                2'b01:   k = K_WRITE;
                2'b00:   k = K_READ;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic [ADDR_W-1:0] cmd_addr(input logic [CMD_W-1:0] b);
        return b[5:1];
    endfunction

endpackage

// File: rtl/cmd_port_sync.sv
module cmd_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sel,
    output logic rise,
    output logic fall,
    output logic sdi_s
);

    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] di;
        logic              ck_prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d         = q;
        d.cs      = {q.cs[STAGES-2:0], cs_n};
        d.ck      = {q.ck[STAGES-2:0], sclk};
        d.di      = {q.di[STAGES-2:0], sdi};
        d.ck_prev = q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cs      <= '1;
            q.ck      <= '0;
            q.di      <= '0;
            q.ck_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sel   = !q.cs[STAGES-1];
    assign rise  = sel &&  q.ck[STAGES-1] && !q.ck_prev;
    assign fall  = sel && !q.ck[STAGES-1] &&  q.ck_prev;
    assign sdi_s = q.di[STAGES-1];

endmodule

// File: rtl/cmd_port_rx.sv
module cmd_port_rx
    import cmd_port_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              sdi_s,
    output logic              instr_stb,
    output logic [CMD_W-1:0]  instr_code,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int WR_BYTES = DATA_W / CMD_W;
    localparam int CNT_W    = $clog2(WR_BYTES + 1);
    localparam int BIT_W    = $clog2(CMD_W);

    typedef struct packed {
        logic [CMD_W-1:0]  sh;
        logic [BIT_W-1:0]  bits;
        logic              wr_pend;
        logic [CNT_W-1:0]  wr_left;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              instr_stb;
        logic [CMD_W-1:0]  instr_code;
        logic              wr_stb;
        logic              rd_stb;
        logic [ADDR_W-1:0] rd_addr;
    } rx_t;

    rx_t d, q;
    logic [CMD_W-1:0] nbyte;

    always_comb begin
        d           = q;
        d.instr_stb = 1'b0;
        d.wr_stb    = 1'b0;
        d.rd_stb    = 1'b0;
        nbyte       = {q.sh[CMD_W-2:0], sdi_s};

        if (!sel) begin
            d.bits    = '0;
            d.wr_pend = 1'b0;
            d.wr_left = '0;
        end else if (rise) begin
            d.sh = nbyte;
            if (q.bits == BIT_W'(CMD_W - 1)) begin
                d.bits = '0;
                if (q.wr_pend) begin
                    // data byte of a pending write: never decoded
                    d.wr_data = {q.wr_data[DATA_W-CMD_W-1:0], nbyte};
                    d.wr_left = q.wr_left - CNT_W'(1);
                    if (q.wr_left == CNT_W'(1)) begin
                        d.wr_pend = 1'b0;
                        d.wr_stb  = 1'b1;
                    end
                end else begin
                    case (classify(nbyte))
                        K_INSTR: begin
                            d.instr_stb  = 1'b1;
                            d.instr_code = nbyte;
                        end
                        K_WRITE: begin
                            d.wr_pend = 1'b1;
                            d.wr_left = CNT_W'(WR_BYTES);
                            d.wr_addr = cmd_addr(nbyte);
                            d.wr_data = '0;
                        end
                        K_READ: begin
                            d.rd_stb  = 1'b1;
                            d.rd_addr = cmd_addr(nbyte);
                        end
                        default: ;
                    endcase
                end
            end else begin
                d.bits = q.bits + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign instr_stb  = q.instr_stb;
    assign instr_code = q.instr_code;
    assign wr_stb     = q.wr_stb;
    assign wr_addr    = q.wr_addr;
    assign wr_data    = q.wr_data;
    assign rd_stb     = q.rd_stb;
    assign rd_addr    = q.rd_addr;

endmodule

// File: rtl/cmd_port_tx.sv
module cmd_port_tx #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              sdo
);

    localparam int LEFT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [LEFT_W-1:0] left;
        logic              sdo;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        if (!sel) begin
            d.left = '0;
            d.sdo  = 1'b0;
        end else if (load) begin
            // a new read replaces whatever is still shifting
            d.sh   = load_data;
            d.left = LEFT_W'(DATA_W);
        end else if (fall) begin
            if (q.left != '0) begin
                d.sdo  = q.sh[DATA_W-1];
                d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                d.left = q.left - LEFT_W'(1);
            end else begin
                d.sdo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo = q.sdo;

endmodule

// File: rtl/cmd_port.sv
module cmd_port
    import cmd_port_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              instr_stb,
    output logic [CMD_W-1:0]  instr_code,
    output logic              reg_wr_stb,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_stb,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data
);

    logic sel;
    logic sclk_rise;
    logic sclk_fall;
    logic sdi_s;

    cmd_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .sel   (sel),
        .rise  (sclk_rise),
        .fall  (sclk_fall),
        .sdi_s (sdi_s)
    );

    cmd_port_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .rise       (sclk_rise),
        .sdi_s      (sdi_s),
        .instr_stb  (instr_stb),
        .instr_code (instr_code),
        .wr_stb     (reg_wr_stb),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_stb     (reg_rd_stb),
        .rd_addr    (reg_rd_addr)
    );

    cmd_port_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .fall      (sclk_fall),
        .load      (reg_rd_stb),
        .load_data (reg_rd_data),
        .sdo       (sdo)
    );

endmodule

// File: rtl/cmd_port_chk.sv
module cmd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       fall,
    input logic       sdo,
    input logic       instr_stb,
    input logic [7:0] instr_code,
    input logic       wr_stb,
    input logic       rd_stb
);

    // R1: deselected port issues nothing and drives sdo low
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!instr_stb && !wr_stb && !rd_stb && !sdo));

    // R6: sdo moves only on a falling serial clock edge
    a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !fall) |=> $stable(sdo));

    // R4 and R3: instruction codes never carry a filler value or a non-11 prefix
    a_r4_instr_code: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |-> (instr_code[7:6] == 2'b11 && instr_code[7:1] != 7'h7F));

    // R10: at most one strobe at a time
    a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_stb, wr_stb, rd_stb}));

    // R10: strobes last a single cycle
    a_r10_instr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |=> !instr_stb);

    a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

endmodule

bind cmd_port cmd_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .fall       (sclk_fall),
    .sdo        (sdo),
    .instr_stb  (instr_stb),
    .instr_code (instr_code),
    .wr_stb     (reg_wr_stb),
    .rd_stb     (reg_rd_stb)
);

// File: tb/cmd_port_bench.sv
`timescale 1ns/1ps
module cmd_port_bench;

    localparam realtime HALF = 50.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        instr_stb;
    logic [7:0]  instr_code;
    logic        reg_wr_stb;
    logic [4:0]  reg_wr_addr;
    logic [23:0] reg_wr_data;
    logic        reg_rd_stb;
    logic [4:0]  reg_rd_addr;
    logic [23:0] reg_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [23:0] reg_val(input logic [4:0] a);
        return {a, 3'b101, ~a, 3'b010, a ^ 5'h15, 3'b110};
    endfunction

    assign reg_rd_data = reg_val(reg_rd_addr);

    cmd_port u_cmd_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .sdo         (sdo),
        .instr_stb   (instr_stb),
        .instr_code  (instr_code),
        .reg_wr_stb  (reg_wr_stb),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_stb  (reg_rd_stb),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data)
    );

    typedef struct {
        int          kind;   // 0 instr, 1 write, 2 read
        logic [7:0]  code;
        logic [4:0]  addr;
        logic [23:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // bench-side model of the host view
    int          b_wr_left = 0;
    logic [4:0]  b_wr_addr;
    logic [23:0] b_wr_data;
    logic [23:0] m_val = '0;
    int          m_left = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input int kind, input logic [7:0] code, input logic [4:0] addr,
                        input logic [23:0] data, input string tag);
        exp_t e;
        e.kind = kind; e.code = code; e.addr = addr; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare strobes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (instr_stb || reg_wr_stb || reg_rd_stb)) begin
            int kind;
            kind = instr_stb ? 0 : (reg_wr_stb ? 1 : 2);
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R3/R9", "unexpected strobe kind", 32'(kind), 32'hFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(kind == e.kind, e.tag, "strobe kind", 32'(kind), 32'(e.kind));
                if (kind == e.kind) begin
                    if (kind == 0)
                        check(instr_code == e.code, e.tag, "instr code", 32'(instr_code), 32'(e.code));
                    else if (kind == 1)
                        check(reg_wr_addr == e.addr && reg_wr_data == e.data, e.tag, "write addr/data",
                              {3'b0, reg_wr_addr, reg_wr_data}, {3'b0, e.addr, e.data});
                    else
                        check(reg_rd_addr == e.addr, e.tag, "read addr", 32'(reg_rd_addr), 32'(e.addr));
                end
            end
        end
    end

    task automatic frame_start();
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic frame_end();
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
        b_wr_left = 0;
        m_left = 0;
        check(sdo == 1'b0, "R1", "sdo while deselected", 32'(sdo), 32'h0);
    endtask

    // shift raw bits without decoding (for partial bytes)
    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            #(HALF);
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    // one full byte; expected strobes pushed, readout bits compared
    task automatic send_byte(input logic [7:0] b, input string tag);
        logic [7:0] got;
        logic [7:0] expb;
        bit         rd_now;
        rd_now = 1'b0;
        if (b_wr_left > 0) begin
            b_wr_data = {b_wr_data[15:0], b};
            b_wr_left--;
            if (b_wr_left == 0) push(1, 8'h0, b_wr_addr, b_wr_data, tag);
        end else if (b == 8'hFF || b == 8'hFE) begin
        end else if (b[7:6] == 2'b11) begin
            push(0, b, 5'h0, 24'h0, tag);
        end else if (b[7:6] == 2'b01) begin
            b_wr_left = 3;
            b_wr_addr = b[5:1];
            b_wr_data = '0;
        end else if (b[7:6] == 2'b00) begin
            push(2, 8'h0, b[5:1], 24'h0, tag);
            rd_now = 1'b1;
        end
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            #(HALF);
            expb[i] = (m_left > 0) ? m_val[23] : 1'b0;
            if (m_left > 0) begin
                m_val = {m_val[22:0], 1'b0};
                m_left--;
            end
            got[i] = sdo;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
        check(got == expb, tag, "readout byte on sdo", 32'(got), 32'(expb));
        if (rd_now) begin
            m_val = reg_val(b[5:1]);
            m_left = 24;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(sdo == 1'b0 && !instr_stb && !reg_wr_stb && !reg_rd_stb, "R1", "reset outputs",
              {28'h0, sdo, instr_stb, reg_wr_stb, reg_rd_stb}, 32'h0);

        // R4, R2 asymmetric code; R3 fillers; R9 ignored prefix
        frame_start();
        send_byte(8'hE1, "R2");
        send_byte(8'hC5, "R4");
        send_byte(8'hFF, "R3");
        send_byte(8'hFE, "R3");
        send_byte(8'h80, "R9");
        send_byte(8'hBF, "R9");
        frame_end();

        // R5: data bytes resembling fillers and instructions
        frame_start();
        send_byte(8'h56, "R5");
        send_byte(8'hFF, "R5");
        send_byte(8'hC3, "R5");
        send_byte(8'h00, "R5");
        send_byte(8'hC9, "R4");
        frame_end();

        // R6: read padded with fillers, fourth byte low
        frame_start();
        send_byte(8'h26, "R6");
        send_byte(8'hFF, "R6");
        send_byte(8'hFE, "R3");
        send_byte(8'hFF, "R6");
        send_byte(8'hFF, "R6");
        frame_end();

        // R7: second read restarts readout
        frame_start();
        send_byte(8'h02, "R7");
        send_byte(8'hFF, "R7");
        send_byte(8'h3E, "R7");
        send_byte(8'hFE, "R7");
        send_byte(8'hFF, "R7");
        send_byte(8'hFE, "R7");
        send_byte(8'hFF, "R7");
        frame_end();

        // R8: instruction and write during readout
        frame_start();
        send_byte(8'h0A, "R8");
        send_byte(8'hD0, "R8");
        send_byte(8'h44, "R8");
        send_byte(8'h12, "R8");
        send_byte(8'h34, "R8");
        send_byte(8'h56, "R8");
        frame_end();

        // R1: partial byte dropped
        frame_start();
        send_bits(8'hC0, 4);
        frame_end();
        frame_start();
        send_byte(8'hC7, "R1");
        frame_end();

        // R1: pending write dropped
        frame_start();
        send_byte(8'h48, "R1");
        send_byte(8'h11, "R1");
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
        b_wr_left = 0;
        m_left = 0;
        frame_start();
        send_byte(8'hCB, "R1");
        frame_end();

        // R1: readout dropped
        frame_start();
        send_byte(8'h06, "R1");
        send_byte(8'hFF, "R1");
        frame_end();
        frame_start();
        send_byte(8'hFF, "R1");
        send_byte(8'hFE, "R1");
        frame_end();

        repeat (20) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R10", "strobes left unseen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule